// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. While its active-low load pin is held low, every stage copies the matching parallel input. Once load is high, each rising edge of an effective shift clock moves the word one stage toward the last stage, and the first stage takes a new bit from the serial input. The effective shift clock is the logical OR of two equivalent pins. Either pin can serve as the clock, and the other then acts as an inhibit: holding it high freezes the register. The last stage drives a true output and a complementary output. Feeding the true output into the serial input of a second unit builds a longer converter.

The load, shift-clock, inhibit, serial and parallel pins are all sampled by a free-running system clock. Shift edges are detected inside the block on the sampled signals. Releasing load never counts as a shift edge. A later rising edge of the effective clock is needed to shift.

Top module: `piso_shifter`

## Requirements
- R1: An active-low asynchronous reset clears every stage, so that q_o=0 and qn_o=1.
- R2: While load_ni is low, stage i takes par_i[i] (bit 0 goes to the first stage, bit W-1 to the last stage). The stages keep following par_i for as long as load_ni stays low.
- R3: While load_ni is low, shclk_i, inh_i and ser_i have no effect. The loaded word is exactly par_i whatever those pins do.
- R4: With load_ni high, each 0-to-1 change of (shclk_i OR inh_i) moves stage i into stage i+1 and ser_i into stage 0. The last stage therefore shows the former stage W-2.
- R5: While inh_i stays high, toggling shclk_i causes no shift. The same holds while the OR stays at 1 for any other reason.
- R6: The two clock pins are interchangeable: a rise of inh_i while shclk_i is low shifts exactly like a rise of shclk_i.
- R7: Raising load_ni back to high does not shift, whether the effective clock is low or high at that time.
- R8: qn_o is always the complement of q_o, and q_o shows the last stage.
- R9: A pin change appears at q_o/qn_o on the third rising edge of clk_i after the change: two synchronizer flops plus the stage register.
- R10: With two units in a chain (the first unit's q_o driving the second unit's ser_i) and 2W shift edges, the chain outputs the concatenated 2W-bit word, most significant bit first. Shift edges are at least three system-clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Parallel load, active low, level sensitive |
| shclk_i | input | 1 | Shift clock pin, one input of the OR |
| inh_i | input | 1 | Clock inhibit pin, the other input of the OR |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | W | Parallel data, bit i to stage i |
| q_o | output | 1 | Last stage |
| qn_o | output | 1 | Complement of the last stage |

## Verification
Every result is due on the third rising system-clock edge after its pin pattern is applied: the synchronizer adds two edges and the stage register one. The bench holds each pin pattern for four cycles and samples one time unit after the last of those edges, so every outcome has settled. One directed case checks the exact latency edge by edge. It confirms that the output is unchanged after the second edge and updated after the third. In the cascade, shift edges are spaced eight cycles apart, so the second unit always samples the first unit's output from before the shift.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned             W       = 1,
  parameter int unsigned             STAGES  = 2,
  parameter logic        [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/piso_edge_ctl.sv
module piso_edge_ctl
  import piso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_n_s_i,
  input  logic shclk_s_i,
  input  logic inh_s_i,
  output op_e  op_o
);
  logic eff_clk;
  logic eff_prev_q;

  assign eff_clk = shclk_s_i | inh_s_i;

  // prev resets high: no edge until a clean low is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_prev_q <= 1'b1;
    else         eff_prev_q <= eff_clk;
  end

  always_comb begin
    if (!load_n_s_i)                 op_o = OP_LOAD;
    else if (eff_clk && !eff_prev_q) op_o = OP_SHIFT;
    else                             op_o = OP_HOLD;
  end

  p_single_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_SHIFT) |=> (op_o != OP_SHIFT));

  p_inhibit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_s_i && $past(inh_s_i)) |-> (op_o != OP_SHIFT));

  p_release_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_s_i && !$past(load_n_s_i) && $stable(eff_clk)) |-> (op_o != OP_SHIFT));
endmodule

// File: rtl/piso_stage_reg.sv
module piso_stage_reg
  import piso_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  op_e          op_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] stage_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      case (op_i)
        OP_LOAD:  stage_q <= par_i;
        OP_SHIFT: stage_q <= {stage_q[W-2:0], ser_i};
        default:  ;
      endcase
    end
  end

  assign stage_o = stage_q;

  p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (stage_q == $past(par_i)));

  p_shift_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (stage_q == {$past(stage_q[W-2:0]), $past(ser_i)}));

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(stage_q));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         shclk_i,
  input  logic         inh_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic         q_o,
  output logic         qn_o
);
  localparam int unsigned SW = W + 4;
  // load_n, shclk, inh reset high; serial and parallel low
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(W+1){1'b0}}};

  logic [SW-1:0] raw, synced;
  logic          load_n_s, shclk_s, inh_s, ser_s;
  logic [W-1:0]  par_s;
  logic [W-1:0]  stage;
  op_e           op;

  assign raw = {load_ni, shclk_i, inh_i, ser_i, par_i};

  piso_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {load_n_s, shclk_s, inh_s, ser_s, par_s} = synced;

  piso_edge_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_n_s_i(load_n_s),
    .shclk_s_i (shclk_s),
    .inh_s_i   (inh_s),
    .op_o      (op)
  );

  piso_stage_reg #(.W(W)) u_stages (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .ser_i  (ser_s),
    .par_i  (par_s),
    .stage_o(stage)
  );

  assign q_o  = stage[W-1];
  assign qn_o = ~stage[W-1];

  p_load_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LOAD) |=> (q_o == $past(par_s[W-1]) && qn_o == !$past(par_s[W-1])));

  p_shift_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SHIFT) |=> (q_o == $past(stage[W-2])));
endmodule

// File: tb/piso_shifter_tb.sv
module piso_shifter_tb;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int HOLD  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1, shclk = 1'b0, inh = 1'b0, ser = 1'b0;
  logic [W-1:0] par_a = '0, par_b = '0;
  logic         qa, qna, qb, qnb;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] ma = '0, mb = '0;
  logic         prev_eff = 1'b0;
  logic [15:0]  stream;

  always #(CLK_P/2) clk = ~clk;

  piso_shifter #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .shclk_i(shclk),
    .inh_i(inh), .ser_i(ser), .par_i(par_a), .q_o(qa), .qn_o(qna));

  piso_shifter #(.W(W)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .shclk_i(shclk),
    .inh_i(inh), .ser_i(qa), .par_i(par_b), .q_o(qb), .qn_o(qnb));

  function automatic logic [W-1:0] next_state(logic [W-1:0] cur, logic ld_n,
                                              logic rise, logic s, logic [W-1:0] p);
    if (!ld_n)     return p;
    else if (rise) return {cur[W-2:0], s};
    return cur;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outs(input string req);
    check(qa == ma[W-1] && qna == ~ma[W-1], req, {14'd0, qa, qna}, {14'd0, ma[W-1], ~ma[W-1]});
    check(qb == mb[W-1] && qnb == ~mb[W-1], req, {14'd0, qb, qnb}, {14'd0, mb[W-1], ~mb[W-1]});
  endtask

  task automatic apply(input logic ld_n, input logic c, input logic e, input logic s,
                       input logic [W-1:0] pa, input logic [W-1:0] pb);
    logic rise;
    logic a_last;
    @(negedge clk);
    load_n = ld_n; shclk = c; inh = e; ser = s; par_a = pa; par_b = pb;
    rise   = (c | e) & ~prev_eff;
    a_last = ma[W-1];
    ma = next_state(ma, ld_n, rise, s, pa);
    mb = next_state(mb, ld_n, rise, a_last, pb);
    prev_eff = c | e;
    repeat (HOLD) @(posedge clk);
    #1;
  endtask

  initial begin : wd
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(qa == 1'b0 && qna == 1'b1, "R1", {14'd0, qa, qna}, 16'h0001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    #1;
    check(qa == 1'b0 && qna == 1'b1, "R1", {14'd0, qa, qna}, 16'h0001);

    // R9 latency: load with last bit 1, watch edge by edge
    @(negedge clk);
    load_n = 1'b0; par_a = 8'h80; par_b = 8'h01;
    @(posedge clk); @(posedge clk); #1;
    check(qa == 1'b0, "R9", {15'd0, qa}, 16'h0000);
    @(posedge clk); #1;
    check(qa == 1'b1 && qna == 1'b0, "R9", {14'd0, qa, qna}, 16'h0002);
    ma = 8'h80; mb = 8'h01;
    repeat (2) @(posedge clk);
    #1;

    // R2 follows parallel inputs while load low
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 8'hFF);
    check_outs("R2");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h00);
    check_outs("R2");

    // R3 clock, inhibit and serial ignored while loading
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h96);
    check_outs("R3");
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h96);
    check_outs("R3");
    // R7 release with effective clock high: no shift
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    check(qa == 1'b0, "R7", {15'd0, qa}, 16'h0000);
    check_outs("R7");

    // R5 inhibit held high, clock toggles
    for (int i = 0; i < 4; i++) begin
      apply(1'b1, i[0], 1'b1, 1'b1, 8'h00, 8'h00);
      check_outs("R5");
    end
    // R4 shifts via clock pin
    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) begin
      apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
      check_outs("R4");
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      check_outs("R4");
    end
    // R6 shift via inhibit pin while clock low
    for (int i = 0; i < 3; i++) begin
      apply(1'b1, 1'b0, 1'b1, i[0], 8'h00, 8'h00);
      check_outs("R6");
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      check_outs("R6");
    end

    // R7 load then release with effective clock low
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hC3);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    check(qa == 1'b0, "R7", {15'd0, qa}, 16'h0000);
    check_outs("R7");
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check(qa == 1'b0, "R7", {15'd0, qa}, 16'h0000);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check(qa == 1'b1, "R7", {15'd0, qa}, 16'h0001);

    // R10 two-unit cascade, 16 bits
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    stream = '0;
    for (int i = 0; i < 2*W; i++) begin
      stream = {stream[14:0], qb};
      apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    end
    check(stream == 16'h3CA5, "R10", stream, 16'h3CA5);
    check_outs("R10");

    // random mix checked against the model (R2 R3 R4 R5 R6 R8)
    for (int i = 0; i < 80; i++) begin
      apply(($urandom % 5) != 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
            W'($urandom), W'($urandom));
      check_outs("R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule